// File: doc/BRIEF.md
# Byte-Wide Host Register Port

This block is the slave end of an 8-bit host bus. An active-low chip select, a read/not-write line and a two-bit register code give a small processor byte access to a 16-bit internal address space. In direct mode the code picks one of four host registers: the low and high bytes of a host address pointer, a plain data window and an auto-incrementing data window. In DMA mode the code pins are ignored. Every access then goes through an internal DMA pointer, which may step after each access, so an external DMA engine can stream bytes without setting up an address.

Behind the windows sit three kinds of storage. A small scratch byte memory stands in for the configuration space. A control page holds the DMA pointer and its step enable. A bank of 32-bit statistics counters is read one byte at a time, and the counter stays consistent across its four bytes. A direct-mode write into a reserved address range raises a one-cycle soft reset that clears the port state.

Top module: `byte_host_port`

## Requirements
- R1: While `rst_n` is low, and after it rises, `rdata` is 0x00, `rdy` is 0 and `soft_rst` is 0. Both host address bytes read back as 0x00.
- R2: An access is any clock edge at which `cs_n` is low. `rd_wr`=1 selects a read and 0 a write. With `dma_n` high, the register codes are 0 for the low host address byte, 1 for the high host address byte, 2 for the plain data window and 3 for the incrementing data window. A read result appears on `rdata` after the access edge and holds until the next read. `rdy` is high for exactly the cycle that follows each access.
- R3: An access through code 2 leaves the host address unchanged. An access through code 3 reads or writes at the host address and then advances it by one.
- R4: With `dma_n` low, the code pins are ignored and data accesses use the DMA pointer. If control bit 0 is 1, the pointer advances by one after each access. If it is 0, the pointer stays put.
- R5: The control page is at 0x6000, where bit 0 is the step enable, with the DMA pointer's low byte at 0x6001 and its high byte at 0x6002; all three read back. If a DMA-mode write lands on a pointer byte, the value written wins over the step.
- R6: Addresses below 0x4000 map to a 64-byte scratch memory indexed by the low 6 address bits. Addresses that differ only above bit 5 alias the same byte.
- R7: Counter i sits at 0x8000+4i, with byte b at offset b and byte 0 as the least significant byte. A counter rises by one in every cycle its `stat_evt` bit is high. Reading byte 0 copies the whole counter into a holding register, and bytes 1 to 3 are returned from that register. If an event arrives in the same cycle as the byte-0 read, the holding register takes the value from before the increment.
- R8: Writes to counter addresses have no effect. Reads of unmapped addresses return 0x00; this covers counter indices at or above the counter count and the range 0x4000 to 0x5FFF.
- R9: A direct-mode write to any address from 0x4000 to 0x5FFF drives `soft_rst` high for one cycle. The next edge clears both pointers, the step enable, the counters and the holding register, and the scratch memory keeps its contents. The same write made through the DMA pointer does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; one access per edge while low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| dma_n | input | 1 | 1 = register code on `addr` used, 0 = DMA pointer used |
| addr | input | 2 | Host register code |
| wdata | input | 8 | Write data |
| stat_evt | input | CNT_N | Per-counter increment events |
| rdata | output | 8 | Read data, registered |
| rdy | output | 1 | One-cycle access acknowledge |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a DMA-mode write lands on the pointer's own low byte while the step enable is set, so the pointer load and the post-access step compete. The bench reads the pointer back through direct mode and expects the written byte, not the written byte plus one. In the second, a counter event is held high through the byte-0 read of that counter. The bench expects bytes 1 to 3 to come from the value before the increment, and a fresh read afterwards to show every increment.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  typedef logic [15:0] addr16_t;

  typedef enum logic [2:0] {RG_RAM, RG_RST, RG_CTL, RG_STAT, RG_NONE} region_e;

  // host register codes on the address pins
  localparam logic [1:0] HR_ALO  = 2'd0;
  localparam logic [1:0] HR_AHI  = 2'd1;
  localparam logic [1:0] HR_DAT  = 2'd2;
  localparam logic [1:0] HR_DATI = 2'd3;

  // control page byte offsets
  localparam logic [1:0] CI_CTRL = 2'd0;
  localparam logic [1:0] CI_PLO  = 2'd1;
  localparam logic [1:0] CI_PHI  = 2'd2;

  function automatic region_e region_of(addr16_t a);
    region_e r;
    if (a[15:14] == 2'b00)                         r = RG_RAM;
    else if (a[15:13] == 3'b010)                   r = RG_RST;
    else if (a[15:13] == 3'b011) begin
      if (a[12:2] == 11'd0 && a[1:0] != 2'b11)     r = RG_CTL;
      else                                         r = RG_NONE;
    end
    else                                           r = RG_STAT;
    return r;
  endfunction

  function automatic addr16_t step_addr(addr16_t a);
    return a + 16'd1;
  endfunction

  function automatic addr16_t set_byte(addr16_t a, logic hi, logic [7:0] b);
    return hi ? {b, a[7:0]} : {a[15:8], b};
  endfunction

  function automatic logic [7:0] byte_pick(logic [31:0] w, logic [1:0] s);
    logic [7:0] r;
    case (s)
      2'd0:    r = w[7:0];
      2'd1:    r = w[15:8];
      2'd2:    r = w[23:16];
      default: r = w[31:24];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bhp_addr_regs.sv
module bhp_addr_regs
  import bhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       host_we_lo,
  input  logic       host_we_hi,
  input  logic       host_step,
  input  logic       ctl_we,
  input  logic [1:0] ctl_idx,
  input  logic       dma_step,
  input  logic [7:0] wdata,
  output addr16_t    host_addr,
  output addr16_t    dma_ptr,
  output logic       ctl_inc,
  output logic       ptr_load
);
  assign ptr_load = ctl_we & (ctl_idx == CI_PLO || ctl_idx == CI_PHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          host_addr <= '0;
    else if (srst)       host_addr <= '0;
    else if (host_we_lo) host_addr <= set_byte(host_addr, 1'b0, wdata);
    else if (host_we_hi) host_addr <= set_byte(host_addr, 1'b1, wdata);
    else if (host_step)  host_addr <= step_addr(host_addr);
  end

  // an explicit pointer load outranks the post-access step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dma_ptr <= '0;
    else if (srst)     dma_ptr <= '0;
    else if (ptr_load) dma_ptr <= set_byte(dma_ptr, ctl_idx == CI_PHI, wdata);
    else if (dma_step) dma_ptr <= step_addr(dma_ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctl_inc <= 1'b0;
    else if (srst)                       ctl_inc <= 1'b0;
    else if (ctl_we && ctl_idx == CI_CTRL) ctl_inc <= wdata[0];
  end
endmodule

// File: rtl/bhp_stat_bank.sv
module bhp_stat_bank
  import bhp_pkg::*;
#(
  parameter int CNT_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [CNT_N-1:0] evt,
  input  logic             rd_en,
  input  logic [14:0]      sel,
  output logic [7:0]       rd_byte
);
  localparam int IDX_W = (CNT_N > 1) ? $clog2(CNT_N) : 1;

  logic [CNT_N-1:0][31:0] cnt;
  logic [31:0]            hold;
  logic [IDX_W-1:0]       idx;
  logic                   hit;
  logic [1:0]             bsel;

  assign idx  = sel[2 +: IDX_W];
  assign hit  = (sel[14:2] < 13'(CNT_N));
  assign bsel = sel[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (srst)  cnt <= '0;
    else begin
      for (int i = 0; i < CNT_N; i++) cnt[i] <= cnt[i] + 32'(evt[i]);
    end
  end

  // byte 0 snapshots the live counter before this edge's increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hold <= '0;
    else if (srst)                           hold <= '0;
    else if (rd_en && hit && bsel == 2'd0)   hold <= cnt[idx];
  end

  always_comb begin
    if (!hit)              rd_byte = 8'h00;
    else if (bsel == 2'd0) rd_byte = byte_pick(cnt[idx], 2'd0);
    else                   rd_byte = byte_pick(hold, bsel);
  end
endmodule

// File: rtl/bhp_scratch.sv
module bhp_scratch #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
  end

  assign rd = mem[a];
endmodule

// File: rtl/byte_host_port.sv
module byte_host_port
  import bhp_pkg::*;
#(
  parameter int CNT_N     = 4,
  parameter int RAM_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_wr,
  input  logic             dma_n,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic [CNT_N-1:0] stat_evt,
  output logic [7:0]       rdata,
  output logic             rdy,
  output logic             soft_rst
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  addr16_t host_addr, dma_ptr, eff;
  logic    ctl_inc, ptr_load;
  region_e rg;

  // named events, also watched by the checker
  logic acc_fire, dma_mode, is_wr, data_acc;
  logic host_we_lo, host_we_hi, pin_step, pin_plain, dma_step, dma_still;
  logic ctl_we, ram_we, stat_rd, rst_hit, dma_rst_wr;
  logic [7:0] ram_q, stat_q, rd_val;

  assign acc_fire   = ~cs_n & ~soft_rst;
  assign dma_mode   = ~dma_n;
  assign is_wr      = ~rd_wr;
  assign data_acc   = acc_fire & (dma_mode | addr[1]);
  assign eff        = dma_mode ? dma_ptr : host_addr;
  assign rg         = region_of(eff);

  assign host_we_lo = acc_fire & ~dma_mode & is_wr & (addr == HR_ALO);
  assign host_we_hi = acc_fire & ~dma_mode & is_wr & (addr == HR_AHI);
  assign pin_step   = acc_fire & ~dma_mode & (addr == HR_DATI);
  assign pin_plain  = acc_fire & ~dma_mode & (addr == HR_DAT);
  assign dma_step   = data_acc & dma_mode & ctl_inc;
  assign ctl_we     = data_acc & is_wr & (rg == RG_CTL);
  assign dma_still  = data_acc & dma_mode & ~ctl_inc & ~ptr_load;
  assign ram_we     = data_acc & is_wr & (rg == RG_RAM);
  assign stat_rd    = data_acc & rd_wr & (rg == RG_STAT);
  assign rst_hit    = data_acc & is_wr & ~dma_mode & (rg == RG_RST);
  assign dma_rst_wr = data_acc & is_wr & dma_mode & (rg == RG_RST);

  bhp_addr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .host_we_lo(host_we_lo), .host_we_hi(host_we_hi), .host_step(pin_step),
    .ctl_we(ctl_we), .ctl_idx(eff[1:0]), .dma_step(dma_step), .wdata(wdata),
    .host_addr(host_addr), .dma_ptr(dma_ptr), .ctl_inc(ctl_inc), .ptr_load(ptr_load)
  );

  bhp_stat_bank #(.CNT_N(CNT_N)) u_stats (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .evt(stat_evt),
    .rd_en(stat_rd), .sel(eff[14:0]), .rd_byte(stat_q)
  );

  bhp_scratch #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .a(eff[RAM_AW-1:0]), .wd(wdata), .rd(ram_q)
  );

  always_comb begin
    rd_val = 8'h00;
    if (!dma_mode && !addr[1]) begin
      rd_val = addr[0] ? host_addr[15:8] : host_addr[7:0];
    end else begin
      case (rg)
        RG_RAM:  rd_val = ram_q;
        RG_STAT: rd_val = stat_q;
        RG_CTL: begin
          case (eff[1:0])
            CI_CTRL: rd_val = {7'd0, ctl_inc};
            CI_PLO:  rd_val = dma_ptr[7:0];
            CI_PHI:  rd_val = dma_ptr[15:8];
            default: rd_val = 8'h00;
          endcase
        end
        default: rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= 8'h00;
      rdy      <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      if (acc_fire && rd_wr) rdata <= rd_val;
      rdy      <= acc_fire;
      soft_rst <= rst_hit;
    end
  end
endmodule

// File: rtl/bhp_chk.sv
module bhp_chk
  import bhp_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    acc_fire,
  input logic    rdy,
  input logic    soft_rst,
  input logic    pin_step,
  input logic    pin_plain,
  input logic    dma_still,
  input logic    dma_rst_wr,
  input addr16_t host_addr,
  input addr16_t dma_ptr
);
  p_rdy_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rdy);
  p_rdy_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !rdy);
  p_plain_keeps_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_plain |=> $stable(host_addr));
  p_inc_steps_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_step |=> host_addr == $past(host_addr) + 16'd1);
  p_dma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_still |=> $stable(dma_ptr));
  p_soft_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  p_soft_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (host_addr == 16'd0 && dma_ptr == 16'd0));
  p_dma_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst_wr |=> !soft_rst);
endmodule

bind byte_host_port bhp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .rdy(rdy),
  .soft_rst(soft_rst), .pin_step(pin_step), .pin_plain(pin_plain),
  .dma_still(dma_still), .dma_rst_wr(dma_rst_wr),
  .host_addr(host_addr), .dma_ptr(dma_ptr)
);

// File: tb/byte_host_port_test.sv
module byte_host_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT = 4;

  typedef struct packed {
    logic       dn;
    logic       rw;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic       chk;
  } vec_t;

  // direct-mode walk: R2 codes, R3 stepping, R6 aliasing
  localparam vec_t [0:15] VT = '{
    '{1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd0, 8'h10, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd3, 8'hA1, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd3, 8'hA2, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd2, 8'hA3, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd2, 8'hA4, 8'h00, 1'b0},
    '{1'b1, 1'b0, 2'd0, 8'h10, 8'h00, 1'b0},
    '{1'b1, 1'b1, 2'd3, 8'h00, 8'hA1, 1'b1},
    '{1'b1, 1'b1, 2'd3, 8'h00, 8'hA2, 1'b1},
    '{1'b1, 1'b1, 2'd2, 8'h00, 8'hA4, 1'b1},
    '{1'b1, 1'b1, 2'd2, 8'h00, 8'hA4, 1'b1},
    '{1'b1, 1'b1, 2'd0, 8'h00, 8'h12, 1'b1},
    '{1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 1'b1},
    '{1'b1, 1'b0, 2'd0, 8'h52, 8'h00, 1'b0},
    '{1'b1, 1'b1, 2'd2, 8'h00, 8'hA4, 1'b1},
    '{1'b1, 1'b1, 2'd0, 8'h00, 8'h52, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_wr = 1'b1, dma_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [NCNT-1:0] stat_evt = '0;
  logic [7:0] rdata;
  logic rdy, soft_rst;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] q;
  logic s, r;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_host_port #(.CNT_N(NCNT), .RAM_DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .dma_n(dma_n),
    .addr(addr), .wdata(wdata), .stat_evt(stat_evt),
    .rdata(rdata), .rdy(rdy), .soft_rst(soft_rst)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // one access; returns after the following falling edge
  task automatic acc(input logic dn, input logic rw, input logic [1:0] a,
                     input logic [7:0] d);
    cs_n = 1'b0; dma_n = dn; rd_wr = rw; addr = a; wdata = d;
    @(negedge clk);
    q = rdata; s = soft_rst; r = rdy;
    cs_n = 1'b1; dma_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic set_addr(input logic [15:0] a);
    acc(1'b1, 1'b0, 2'd1, a[15:8]);
    acc(1'b1, 1'b0, 2'd0, a[7:0]);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    set_addr(a);
    acc(1'b1, 1'b0, 2'd2, d);
  endtask

  task automatic peek(input logic [15:0] a, input string tag, input logic [7:0] exp);
    set_addr(a);
    acc(1'b1, 1'b1, 2'd2, 8'h00);
    chk(tag, q, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 8'h00);
    chk("R1 rdy in reset", {7'd0, rdy}, 8'h00);
    chk("R1 soft_rst in reset", {7'd0, soft_rst}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b1, 1'b1, 2'd0, 8'h00); chk("R1 addr low after reset", q, 8'h00);
    acc(1'b1, 1'b1, 2'd1, 8'h00); chk("R1 addr high after reset", q, 8'h00);
    chk("R2 rdy after access", {7'd0, r}, 8'h01);
    @(negedge clk);
    chk("R2 rdy idle", {7'd0, rdy}, 8'h00);

    // table walk (R2, R3, R6)
    for (int i = 0; i < 16; i++) begin
      acc(VT[i].dn, VT[i].rw, VT[i].a, VT[i].d);
      if (VT[i].chk) chk($sformatf("R2/R3/R6 vector %0d", i), q, VT[i].exp);
    end

    // DMA mode (R4): pointer 0x0020, step enabled
    poke(16'h6001, 8'h20);
    poke(16'h6002, 8'h00);
    poke(16'h6000, 8'h01);
    acc(1'b0, 1'b0, 2'd1, 8'hB0);
    acc(1'b0, 1'b0, 2'd0, 8'hB1);
    poke(16'h6000, 8'h00);
    acc(1'b0, 1'b0, 2'd1, 8'hB2);
    acc(1'b0, 1'b0, 2'd3, 8'hB3);
    set_addr(16'h0020);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R4 dma byte 0x20", q, 8'hB0);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R4 dma byte 0x21", q, 8'hB1);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R4 dma hold overwrite 0x22", q, 8'hB3);
    peek(16'h6001, "R4 pointer low", 8'h22);
    acc(1'b0, 1'b1, 2'd2, 8'h00); chk("R4 dma read without step", q, 8'hB3);
    peek(16'h6001, "R4 pointer unchanged by read", 8'h22);

    // R5: pointer aimed at its own low byte with step on
    poke(16'h6001, 8'h01);
    poke(16'h6002, 8'h60);
    poke(16'h6000, 8'h01);
    acc(1'b0, 1'b0, 2'd0, 8'h40);
    peek(16'h6001, "R5 load wins over step", 8'h40);
    peek(16'h6002, "R5 pointer high", 8'h60);
    peek(16'h6000, "R5 control readback", 8'h01);

    // R7: coherent counter read with event held through byte 0
    set_addr(16'h8000);
    stat_evt[0] = 1'b1;
    repeat (255) @(negedge clk);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 byte0 snapshot", q, 8'hFF);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 byte1 from holding", q, 8'h00);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 byte2 from holding", q, 8'h00);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 byte3 from holding", q, 8'h00);
    stat_evt[0] = 1'b0;
    set_addr(16'h8000);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 recount byte0", q, 8'h03);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 recount byte1", q, 8'h01);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 recount byte2", q, 8'h00);

    stat_evt[1] = 1'b1;
    repeat (300) @(negedge clk);
    stat_evt[1] = 1'b0;
    poke(16'h8004, 8'h55);  // R8 write ignored
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 R8 counter1 byte0", q, 8'h2C);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 R8 counter1 byte1", q, 8'h01);
    acc(1'b1, 1'b1, 2'd3, 8'h00); chk("R7 counter1 byte2", q, 8'h00);
    peek(16'h8010, "R8 unmapped counter", 8'h00);
    peek(16'h4010, "R8 reset range read", 8'h00);
    chk("R8 read no reset", {7'd0, s}, 8'h00);

    // R9: DMA path into reset range does nothing
    poke(16'h6001, 8'h00);
    poke(16'h6002, 8'h40);
    acc(1'b0, 1'b0, 2'd2, 8'h77);
    chk("R9 dma write no pulse", {7'd0, s}, 8'h00);
    @(negedge clk);
    chk("R9 dma write no pulse later", {7'd0, soft_rst}, 8'h00);
    peek(16'h6000, "R9 control kept after dma write", 8'h01);

    // R9: direct path triggers the soft reset
    poke(16'h4123, 8'h00);
    chk("R9 soft reset pulse", {7'd0, s}, 8'h01);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'd0, soft_rst}, 8'h00);
    acc(1'b1, 1'b1, 2'd0, 8'h00); chk("R9 host addr low cleared", q, 8'h00);
    acc(1'b1, 1'b1, 2'd1, 8'h00); chk("R9 host addr high cleared", q, 8'h00);
    peek(16'h6000, "R9 control cleared", 8'h00);
    peek(16'h6002, "R9 pointer cleared", 8'h00);
    peek(16'h8000, "R9 counter cleared", 8'h00);
    peek(16'h0010, "R9 scratch kept", 8'hA1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule